// File: doc/BRIEF.md
# Serial Register Loader with Staged Commit

This block is a three-wire serial write slave that sits beside a bank of eight 12-bit control registers. A host lowers an active-low load strobe, then clocks bits in on a serial clock. Each frame opens with a 3-bit register address sent least significant bit first. A reserved test bit follows, and then one or more 12-bit data words, each also sent least significant bit first. Each finished word lands in a shadow copy of the addressed register. The address then steps up by one, so further words can follow back to back while the strobe stays low.

Nothing reaches the live registers during a frame. When the strobe rises, the whole shadow bank is copied into the live bank in one system clock cycle. The live bank is driven in parallel to the rest of the chip. The serial clock, data and strobe are brought into the system clock domain through short flop synchronizers, and the serial clock is edge-detected there. The serial clock must therefore run well below the system clock.

Top module: `serial_reg_loader`

## Requirements
- R1: Serial data is taken only on a rising serial clock edge while the strobe is low. Serial clock edges while the strobe is high change no register.
- R2: A frame carries bits in this order: address bits 0, 1, 2, then the test bit, then data bits 0 to 11. A single write is therefore 16 serial clock rises. Register n appears on `live_regs[12*n +: 12]`.
- R3: Live registers change only when the strobe rises. The new values appear on `live_regs` 3 system clock cycles after the strobe input goes high: two synchronizer stages plus the commit register.
- R4: With the strobe held low, each further 12-bit word is written to the register one above the one written before it.
- R5: The word address wraps from 7 to 0 when more than eight words arrive in one frame. A later word to the same register overwrites the earlier one.
- R6: Bits of an unfinished word (fewer than 12 data bits) present when the strobe rises are discarded. No register takes them.
- R7: A test bit of 1 sets `test_bit_err`. The flag stays set until reset, and the frame is still written normally.
- R8: After reset all live registers read 0 and `test_bit_err` is 0.
- R9: A high strobe clears the frame position, so every frame starts with address bit 0 even after an aborted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; data taken on its rising edge |
| sdata | input | 1 | Serial data, least significant bit first |
| sl_n | input | 1 | Active-low load strobe; rising edge commits shadow to live |
| live_regs | output | 96 | Live register bank, register n at bits 12n+11 down to 12n |
| test_bit_err | output | 1 | Sticky flag, set when a frame's test bit was 1 |

## Verification
Every result is due 3 system clock cycles after the input edge that causes it. A rising strobe shows up on the live bank at that point, and a test bit of 1 shows up on the error flag at that point. Every other cycle the outputs must hold. The bench drives inputs on falling clock edges. Its behavioural model holds each expected change in a countdown of three rising edges. The outputs are compared against the model 1 ns after every rising edge, so any early, late or spurious change is caught in the exact cycle it happens.

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
  parameter int ADDR_W   = 3,
  parameter int WORD_W   = 12,
  parameter int SYNC_LEN = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sck,
  input  logic                            sdata,
  input  logic                            sl_n,
  output logic [(1<<ADDR_W)*WORD_W-1:0]   live_regs,
  output logic                            test_bit_err
);
  localparam int NREG     = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam int HDR_BITS = ADDR_W + 1;
  localparam int HDR_W    = $clog2(HDR_BITS + 1);

  logic [SYNC_LEN:0]   sck_p;
  logic [SYNC_LEN:0]   sl_p;
  logic [SYNC_LEN-1:0] sd_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sl_p  <= '1;
      sd_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_LEN-1:0], sck};
      sl_p  <= {sl_p[SYNC_LEN-1:0], sl_n};
      sd_p  <= {sd_p[SYNC_LEN-2:0], sdata};
    end
  end

  logic sck_rise, sl_rise, in_frame, bit_in;
  assign sck_rise = sck_p[SYNC_LEN-1] & ~sck_p[SYNC_LEN];
  assign sl_rise  = sl_p[SYNC_LEN-1] & ~sl_p[SYNC_LEN];
  assign in_frame = ~sl_p[SYNC_LEN-1];
  assign bit_in   = sd_p[SYNC_LEN-1];

  logic [HDR_W-1:0]  hdr_cnt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_sr, nxt_word;
  logic              in_data, take, word_done;

  assign in_data   = (hdr_cnt == HDR_W'(HDR_BITS));
  assign take      = in_frame & sck_rise;
  assign nxt_word  = {bit_in, word_sr[WORD_W-1:1]};
  assign word_done = take & in_data & (bit_cnt == CNT_W'(WORD_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_cnt <= '0;
      bit_cnt <= '0;
      addr_q  <= '0;
      word_sr <= '0;
    end else if (!in_frame) begin
      hdr_cnt <= '0;
      bit_cnt <= '0;
      word_sr <= '0;
    end else if (take) begin
      if (!in_data) begin
        for (int i = 0; i < ADDR_W; i++)
          if (hdr_cnt == HDR_W'(i)) addr_q[i] <= bit_in;
        hdr_cnt <= hdr_cnt + HDR_W'(1);
      end else begin
        word_sr <= nxt_word;
        if (word_done) begin
          bit_cnt <= '0;
          addr_q  <= addr_q + ADDR_W'(1);
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      test_bit_err <= 1'b0;
    else if (take && hdr_cnt == HDR_W'(ADDR_W) && bit_in)
      test_bit_err <= 1'b1;
  end

  logic [WORD_W-1:0] shadow_q [NREG];
  logic [WORD_W-1:0] live_q   [NREG];
  logic [NREG*WORD_W-1:0] shadow_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
    end else if (word_done) begin
      shadow_q[addr_q] <= nxt_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= '0;
    end else if (sl_rise) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= shadow_q[i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign live_regs[g*WORD_W +: WORD_W]   = live_q[g];
    assign shadow_flat[g*WORD_W +: WORD_W] = shadow_q[g];
  end

  AST_LIVE_HOLDS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sl_rise |=> $stable(live_regs)); // R3
  AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> $stable(shadow_flat)); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    test_bit_err |=> test_bit_err); // R7
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> (hdr_cnt == '0 && bit_cnt == '0)); // R9
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(WORD_W)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R4
endmodule

// File: tb/serial_reg_loader_tb_top.sv
module serial_reg_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdata = 1'b0, sl_n = 1'b1;
  logic [95:0] live_regs;
  logic test_bit_err;

  always #5 clk = ~clk;

  serial_reg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdata(sdata), .sl_n(sl_n),
    .live_regs(live_regs), .test_bit_err(test_bit_err)
  );

  int checks = 0, fails = 0;
  string cur_req = "R8";
  int exp_shadow [8];
  int exp_commit [8];
  int exp_live [8];
  bit exp_err = 0;
  int pend_live = 0, pend_err = 0;
  int wq [$];
  bit done = 0;

  initial forever begin
    @(posedge clk);
    #1;
    if (pend_live > 0) begin
      pend_live--;
      if (pend_live == 0) exp_live = exp_commit;
    end
    if (pend_err > 0) begin
      pend_err--;
      if (pend_err == 0) exp_err = 1'b1;
    end
    if (rst_n && !done) begin
      checks++;
      for (int i = 0; i < 8; i++) begin
        if (live_regs[i*12 +: 12] != 12'(exp_live[i])) begin
          fails++;
          $display("FAIL %s reg %0d actual %h expected %h at %0t", cur_req, i,
                   live_regs[i*12 +: 12], 12'(exp_live[i]), $time);
          break;
        end
      end
      checks++;
      if (test_bit_err != exp_err) begin
        fails++;
        $display("FAIL R7 test_bit_err actual %0b expected %0b at %0t",
                 test_bit_err, exp_err, $time);
      end
    end
  end

  task automatic send_bit(input bit b, input bit mark_err);
    @(negedge clk) sdata = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    if (mark_err) pend_err = 3;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic strobe_high();
    repeat (4) @(negedge clk);
    sl_n = 1'b1;
    exp_commit = exp_shadow;
    pend_live = 3;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input int a, input int pn, input int pv, input bit tb, input int hold);
    int addr = a;
    @(negedge clk) sl_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) send_bit(a[i], 1'b0);
    send_bit(tb, tb);
    foreach (wq[k]) begin
      for (int i = 0; i < 12; i++) send_bit(wq[k][i], 1'b0);
      exp_shadow[addr] = wq[k] & 12'hFFF;
      addr = (addr + 1) % 8;
    end
    for (int i = 0; i < pn; i++) send_bit(pv[i], 1'b0);
    repeat (hold) @(negedge clk);
    strobe_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin exp_shadow[i] = 0; exp_live[i] = 0; exp_commit[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R8";
    repeat (10) @(negedge clk);

    cur_req = "R2";
    wq = '{12'hA5C};
    frame(2, 0, 0, 1'b0, 0);

    cur_req = "R3";
    wq = '{12'h3C1};
    frame(0, 0, 0, 1'b0, 60);

    cur_req = "R4";
    wq = '{12'h111, 12'h222, 12'h333};
    frame(4, 0, 0, 1'b0, 0);

    cur_req = "R5";
    wq = '{12'h601, 12'h702, 12'h003, 12'h104, 12'h205, 12'h306, 12'h407, 12'h508, 12'hF09};
    frame(6, 0, 0, 1'b0, 0);

    cur_req = "R6";
    wq = '{12'h8E7};
    frame(1, 7, 7'h55, 1'b0, 0);

    cur_req = "R1";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) sdata = i[0] ^ i[2];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    wq = '{12'h7B2};
    frame(7, 0, 0, 1'b0, 0);

    cur_req = "R9";
    @(negedge clk) sl_n = 1'b0;
    repeat (4) @(negedge clk);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    strobe_high();
    wq = '{12'h0D5};
    frame(5, 0, 0, 1'b0, 0);

    cur_req = "R7";
    wq = '{12'hC3A};
    frame(3, 0, 0, 1'b1, 0);
    wq = '{12'h246};
    frame(2, 0, 0, 1'b0, 0);

    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule